// File: doc/BRIEF.md
# Three-Level Priority Interrupt Controller

This block gathers single-cycle request pulses from a parameterised set of sources and holds each one in a byte-wide pending register. Each source is given a two-bit priority code. One bit of that code comes from an enable-high register and the other from an enable-low register, at the same bit position. The code selects one of three levels, or switches the source off. While the global-enable input is high, the controller drives a level interrupt to the CPU, together with the index of the winning source. While global enable is low, nothing is forwarded, and software polls the pending registers over the register bus.

Pending bits are cleared in two ways. Software can write a one to the bit, or the CPU can acknowledge the source currently shown on the vector output. A new request that arrives in the same cycle as either kind of clear wins, so no event is lost. Source `i` lives in bank `i/8`, bit `i%8`.

The register address is `{bank, select}`. The bank occupies the upper bits and the 2-bit select the lower bits:

| Select code | Register |
|---|---|
| 0 | pending register |
| 1 | enable-high register |
| 2 | enable-low register |
| 3 | unmapped |

With 20 sources there are three banks, so the pending, enable-high and enable-low addresses are 0/1/2, 4/5/6 and 8/9/10.

Top module: `prio_irq_ctrl`

## Requirements
- R1: A synchronous reset clears every pending, enable-high and enable-low bit, and clears `int_out` and `reg_rdata`.
- R2: A one on `src_req[i]` at a clock edge sets pending bit `i`. The bit stays set until it is cleared.
- R3: Writing the pending register clears each bit written as 1 and leaves each bit written as 0 unchanged. A request in the same cycle as a clear leaves the bit set.
- R4: Pending bits for sources at index `SRC_COUNT` or above always read 0, and neither requests nor writes can set them. With the default of 20 sources these are bank 2, bits 7:4. Select code 3 reads 0.
- R5: The enable-high and enable-low registers are 8-bit read/write. `reg_rdata` returns the addressed register one cycle after `reg_rd`.
- R6: A source's level is the 2-bit code `{enable-high bit, enable-low bit}`, where 00 is off, 01 is low, 10 is nominal and 11 is high. A pending source with code 00 stays readable but never raises `int_out`.
- R7: Among pending sources that are switched on, the highest level wins. Within a level, the lowest source index wins.
- R8: While `glob_en` is low, `int_out` is low and the pending registers remain readable. Raising `glob_en` again forwards the winner.
- R9: `int_out` is a registered level that stays high while a winner exists. Whenever `int_out` is high, `int_vec` holds the winner's index, which is below `SRC_COUNT`. Both outputs reflect the register state after the same clock edge.
- R10: A pulse on `int_ack` while `int_out` is high clears the pending bit of the source on `int_vec`, unless that source requests again in the same cycle. A pulse on `int_ack` while `int_out` is low has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | ADDR_W | Register address: bank number above a 2-bit select |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | 8 | Registered read data |
| src_req | input | SRC_COUNT | Request pulses, one bit per source |
| glob_en | input | 1 | Global interrupt enable |
| int_out | output | 1 | Interrupt request to the CPU (level) |
| int_vec | output | VEC_W | Index of the winning source |
| int_ack | input | 1 | Acknowledge pulse from the CPU |

## Verification
Assertions check the following on every cycle:
- every request lands in its pending bit;
- reserved pending bits stay zero;
- a forwarded interrupt always names a pending source that is switched on, with an index in range;
- `glob_en` low silences the output;
- an acknowledge removes the acknowledged source.

Only the bench scenarios can show that the correct source wins among several candidates, including level order and ties within a level. They also show the write-one-to-clear behaviour against writes of zero, the race between a request and a clear, and acknowledges that arrive while the interrupt is low.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
  localparam int REG_W = 8;
  localparam int SEL_W = 2;

  typedef enum logic [SEL_W-1:0] {
    SEL_PEND = 2'd0,
    SEL_ENH  = 2'd1,
    SEL_ENL  = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  typedef enum logic [1:0] {
    LVL_OFF  = 2'b00,
    LVL_LOW  = 2'b01,
    LVL_MID  = 2'b10,
    LVL_HIGH = 2'b11
  } prio_lvl_e;
endpackage

// File: rtl/prio_irq_pend_bank.sv
module prio_irq_pend_bank #(
  parameter int W    = 8,
  parameter int LIVE = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] pend_q_o,
  output logic [W-1:0] pend_d_o
);
  localparam logic [W-1:0] LIVE_MASK = (LIVE >= W) ? {W{1'b1}} : W'((1 << LIVE) - 1);

  logic [W-1:0] pend_q;

  // set has priority over any clear in the same cycle
  assign pend_d_o = ((pend_q & ~clr_i) | set_i) & LIVE_MASK;
  assign pend_q_o = pend_q;

  always_ff @(posedge clk) begin
    if (rst) pend_q <= '0;
    else     pend_q <= pend_d_o;
  end
endmodule

// File: rtl/prio_irq_en_reg.sv
module prio_irq_en_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] q_o,
  output logic [W-1:0] d_o
);
  logic [W-1:0] q;

  assign d_o = wr_i ? wdata_i : q;
  assign q_o = q;

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= d_o;
  end
endmodule

// File: rtl/prio_irq_arb.sv
module prio_irq_arb #(
  parameter int N     = 20,
  parameter int IDX_W = 5
) (
  input  logic [N-1:0]     pend_i,
  input  logic [N-1:0]     hi_i,
  input  logic [N-1:0]     lo_i,
  input  logic             gate_i,
  output logic             hit_o,
  output logic [IDX_W-1:0] idx_o
);
  logic [1:0] best;
  logic       any;

  // ascending scan with strict compare: lowest index wins a tie
  always_comb begin
    best  = 2'b00;
    any   = 1'b0;
    idx_o = '0;
    for (int i = 0; i < N; i++) begin
      if (pend_i[i] && ({hi_i[i], lo_i[i]} > best)) begin
        best  = {hi_i[i], lo_i[i]};
        idx_o = IDX_W'(i);
        any   = 1'b1;
      end
    end
    hit_o = any & gate_i;
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import prio_irq_pkg::*;
#(
  parameter int SRC_COUNT = 20,
  parameter int NBANK     = (SRC_COUNT + REG_W - 1) / REG_W,
  parameter int BANK_W    = (NBANK > 1) ? $clog2(NBANK) : 1,
  parameter int ADDR_W    = BANK_W + SEL_W,
  parameter int VEC_W     = (SRC_COUNT > 1) ? $clog2(SRC_COUNT) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic                 reg_wr,
  input  logic [REG_W-1:0]     reg_wdata,
  input  logic                 reg_rd,
  output logic [REG_W-1:0]     reg_rdata,
  input  logic [SRC_COUNT-1:0] src_req,
  input  logic                 glob_en,
  output logic                 int_out,
  output logic [VEC_W-1:0]     int_vec,
  input  logic                 int_ack
);
  localparam int SRC_PAD = NBANK * REG_W;

  logic [BANK_W-1:0] bank_sel;
  reg_sel_e          sel;
  logic [SRC_PAD-1:0] req_pad, ack_mask;
  logic [SRC_PAD-1:0] pend_q, pend_d, enh_q, enh_d, enl_q, enl_d;
  logic [REG_W-1:0]  rd_mux;
  logic              arb_hit;
  logic [VEC_W-1:0]  arb_idx;

  assign bank_sel = reg_addr[ADDR_W-1:SEL_W];
  assign sel      = reg_sel_e'(reg_addr[SEL_W-1:0]);
  assign req_pad  = SRC_PAD'(src_req);
  assign ack_mask = (int_ack && int_out) ? (SRC_PAD'(1) << int_vec) : '0;

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    localparam int LIVE = (SRC_COUNT - b * REG_W >= REG_W) ? REG_W : (SRC_COUNT - b * REG_W);
    logic             hit_b;
    logic [REG_W-1:0] clr_b;

    assign hit_b = (bank_sel == BANK_W'(b));
    assign clr_b = ((reg_wr && hit_b && sel == SEL_PEND) ? reg_wdata : '0)
                 | ack_mask[b*REG_W +: REG_W];

    prio_irq_pend_bank #(.W(REG_W), .LIVE(LIVE)) u_pend (
      .clk      (clk),
      .rst      (rst),
      .set_i    (req_pad[b*REG_W +: REG_W]),
      .clr_i    (clr_b),
      .pend_q_o (pend_q[b*REG_W +: REG_W]),
      .pend_d_o (pend_d[b*REG_W +: REG_W])
    );

    prio_irq_en_reg #(.W(REG_W)) u_enh (
      .clk     (clk),
      .rst     (rst),
      .wr_i    (reg_wr && hit_b && sel == SEL_ENH),
      .wdata_i (reg_wdata),
      .q_o     (enh_q[b*REG_W +: REG_W]),
      .d_o     (enh_d[b*REG_W +: REG_W])
    );

    prio_irq_en_reg #(.W(REG_W)) u_enl (
      .clk     (clk),
      .rst     (rst),
      .wr_i    (reg_wr && hit_b && sel == SEL_ENL),
      .wdata_i (reg_wdata),
      .q_o     (enl_q[b*REG_W +: REG_W]),
      .d_o     (enl_d[b*REG_W +: REG_W])
    );
  end

  always_comb begin
    rd_mux = '0;
    for (int b = 0; b < NBANK; b++) begin
      if (bank_sel == BANK_W'(b)) begin
        case (sel)
          SEL_PEND: rd_mux = pend_q[b*REG_W +: REG_W];
          SEL_ENH:  rd_mux = enh_q[b*REG_W +: REG_W];
          SEL_ENL:  rd_mux = enl_q[b*REG_W +: REG_W];
          default:  rd_mux = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_mux;
  end

  // arbitrate on next-state values so the outputs line up with the registers
  prio_irq_arb #(.N(SRC_COUNT), .IDX_W(VEC_W)) u_arb (
    .pend_i (pend_d[SRC_COUNT-1:0]),
    .hi_i   (enh_d[SRC_COUNT-1:0]),
    .lo_i   (enl_d[SRC_COUNT-1:0]),
    .gate_i (glob_en),
    .hit_o  (arb_hit),
    .idx_o  (arb_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      int_out <= 1'b0;
      int_vec <= '0;
    end else begin
      int_out <= arb_hit;
      int_vec <= arb_idx;
    end
  end
endmodule

// File: rtl/prio_irq_chk.sv
module prio_irq_chk #(
  parameter int SRC_COUNT = 20,
  parameter int SRC_PAD   = 24,
  parameter int VEC_W     = 5
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 glob_en,
  input logic [SRC_COUNT-1:0] src_req,
  input logic                 int_ack,
  input logic                 int_out,
  input logic [VEC_W-1:0]     int_vec,
  input logic [SRC_PAD-1:0]   pend_q,
  input logic [SRC_PAD-1:0]   enh_q,
  input logic [SRC_PAD-1:0]   enl_q
);
  a_r1_out_low_after_reset: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> !int_out);

  a_r2_req_latched: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pend_q[SRC_COUNT-1:0] & $past(src_req)) == $past(src_req)));

  if (SRC_PAD > SRC_COUNT) begin : g_rsv
    a_r4_reserved_zero: assert property (@(posedge clk) disable iff (rst)
      pend_q[SRC_PAD-1:SRC_COUNT] == '0);
  end

  a_r6_winner_enabled: assert property (@(posedge clk) disable iff (rst)
    int_out |-> (pend_q[int_vec] && ({enh_q[int_vec], enl_q[int_vec]} != 2'b00)));

  a_r8_gate_off: assert property (@(posedge clk) disable iff (rst)
    !$past(glob_en) |-> !int_out);

  a_r9_vec_range: assert property (@(posedge clk) disable iff (rst)
    int_out |-> (int_vec < VEC_W'(SRC_COUNT)));

  a_r10_ack_clears: assert property (@(posedge clk) disable iff (rst)
    (int_ack && int_out && !src_req[int_vec]) |=> !pend_q[$past(int_vec)]);
endmodule

bind prio_irq_ctrl prio_irq_chk #(
  .SRC_COUNT (SRC_COUNT),
  .SRC_PAD   (NBANK * 8),
  .VEC_W     (VEC_W)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .glob_en (glob_en),
  .src_req (src_req),
  .int_ack (int_ack),
  .int_out (int_out),
  .int_vec (int_vec),
  .pend_q  (pend_q),
  .enh_q   (enh_q),
  .enl_q   (enl_q)
);

// File: tb/prio_irq_ctrl_tb.sv
`timescale 1ns/1ps
module prio_irq_ctrl_tb;
  localparam int SRC = 20;
  localparam int AW  = 4;
  localparam int VW  = 5;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] reg_addr = '0;
  logic          reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0]    reg_wdata = '0;
  logic [7:0]    reg_rdata;
  logic [SRC-1:0] src_req = '0;
  logic          glob_en = 1'b0;
  logic          int_out;
  logic [VW-1:0] int_vec;
  logic          int_ack = 1'b0;

  int total = 0, bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  prio_irq_ctrl #(.SRC_COUNT(SRC)) u_dut (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
    .src_req(src_req), .glob_en(glob_en), .int_out(int_out),
    .int_vec(int_vec), .int_ack(int_ack)
  );

  // op codes: 0 write, 1 read-check, 2 request pulse, 3 interrupt check, 4 set glob_en
  // entry: {op[3:0], addr[3:0], data[23:0], expect[7:0]}; interrupt expect = {int_out,2'b0,vec[4:0]}
  localparam int NV = 39;
  localparam logic [39:0] TBL [NV] = '{
    {4'd4, 4'h0, 24'h000001, 8'h00},  // R8 enable
    {4'd2, 4'h0, 24'h000020, 8'h00},  // R2 src5
    {4'd1, 4'h0, 24'h000000, 8'h20},  // R2
    {4'd3, 4'h0, 24'h000000, 8'h00},  // R6 code 00 silent
    {4'd0, 4'h2, 24'h000020, 8'h00},  // R6 src5 low
    {4'd3, 4'h0, 24'h000000, 8'h85},  // R6
    {4'd2, 4'h0, 24'h001000, 8'h00},  // R2 src12
    {4'd0, 4'h5, 24'h000010, 8'h00},  // R6 src12 nominal
    {4'd3, 4'h0, 24'h000000, 8'h8C},  // R7
    {4'd2, 4'h0, 24'h000008, 8'h00},  // R2 src3
    {4'd0, 4'h1, 24'h000008, 8'h00},
    {4'd0, 4'h2, 24'h000028, 8'h00},  // src3 high
    {4'd3, 4'h0, 24'h000000, 8'h83},  // R7
    {4'd4, 4'h0, 24'h000000, 8'h00},  // R8 disable
    {4'd3, 4'h0, 24'h000000, 8'h00},  // R8
    {4'd1, 4'h0, 24'h000000, 8'h28},  // R8 polled
    {4'd4, 4'h0, 24'h000001, 8'h00},
    {4'd3, 4'h0, 24'h000000, 8'h83},  // R8
    {4'd0, 4'h0, 24'h000008, 8'h00},  // R3 clear src3
    {4'd3, 4'h0, 24'h000000, 8'h8C},  // R3
    {4'd1, 4'h0, 24'h000000, 8'h20},  // R3
    {4'd0, 4'h0, 24'h000000, 8'h00},  // R3 zero write
    {4'd1, 4'h0, 24'h000000, 8'h20},  // R3
    {4'd2, 4'h0, 24'h000002, 8'h00},  // R2 src1
    {4'd0, 4'h1, 24'h000002, 8'h00},  // src1 nominal
    {4'd3, 4'h0, 24'h000000, 8'h81},  // R7 tie
    {4'd0, 4'h0, 24'h000002, 8'h00},  // R3
    {4'd3, 4'h0, 24'h000000, 8'h8C},  // R7
    {4'd2, 4'h0, 24'h0F0000, 8'h00},  // R4 src16..19
    {4'd1, 4'h8, 24'h000000, 8'h0F},  // R4
    {4'd0, 4'h8, 24'h0000F0, 8'h00},  // R4 reserved write
    {4'd1, 4'h8, 24'h000000, 8'h0F},  // R4
    {4'd0, 4'h9, 24'h0000A5, 8'h00},  // R5
    {4'd1, 4'h9, 24'h000000, 8'hA5},  // R5
    {4'd0, 4'hA, 24'h00005A, 8'h00},  // R5
    {4'd1, 4'hA, 24'h000000, 8'h5A},  // R5
    {4'd1, 4'h3, 24'h000000, 8'h00},  // R4 unmapped select
    {4'd3, 4'h0, 24'h000000, 8'h8C},  // R7 index tie 12 vs 16
    {4'd1, 4'h1, 24'h000000, 8'h02}   // R5
  };
  localparam string TAG [NV] = '{
    "R8","R2","R2","R6","R6","R6","R2","R6","R7","R2","R6","R6","R7",
    "R8","R8","R8","R8","R8","R3","R3","R3","R3","R3","R2","R7","R7",
    "R3","R7","R4","R4","R4","R4","R5","R5","R5","R5","R4","R7","R5"};

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    reg_wr = 1'b0; reg_rd = 1'b0; src_req = '0; int_ack = 1'b0;
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1; step();
  endtask

  task automatic rd(input string tag, input logic [3:0] a, input logic [7:0] e);
    reg_addr = a; reg_rd = 1'b1; step();
    chk(tag, int'(reg_rdata), int'(e));
  endtask

  task automatic irq(input string tag, input logic [7:0] e);
    if (e[7]) chk(tag, int'({int_out, 2'b00, int_vec}), int'(e));
    else      chk(tag, int'(int_out), 0);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=done");
    finish_run();
  end

  initial begin
    @(negedge clk); step(); step();
    rst = 1'b0;
    // R1 reset state
    chk("R1", int'(int_out), 0);
    chk("R1", int'(reg_rdata), 0);
    for (int a = 0; a < 11; a++) rd("R1", 4'(a), 8'h00);

    for (int k = 0; k < NV; k++) begin
      case (TBL[k][39:36])
        4'd0: wr(TBL[k][35:32], TBL[k][15:8]);
        4'd1: rd(TAG[k], TBL[k][35:32], TBL[k][7:0]);
        4'd2: begin src_req = TBL[k][SRC+7:8]; step(); end
        4'd3: irq(TAG[k], TBL[k][7:0]);
        default: begin glob_en = TBL[k][8]; step(); end
      endcase
    end

    // R9 level holds with no new events
    step(); step();
    irq("R9", 8'h8C);
    // R10 acknowledge clears src12, src16 (nominal) takes over
    int_ack = 1'b1; step();
    irq("R10", 8'h90);
    rd("R10", 4'h4, 8'h00);
    // R10/R3 ack racing a new request from the same source
    int_ack = 1'b1; src_req = 20'h10000; step();
    irq("R10", 8'h90);
    rd("R3", 4'h8, 8'h0F);
    // R3 write-one-to-clear racing a request
    reg_addr = 4'h0; reg_wdata = 8'h20; reg_wr = 1'b1; src_req = 20'h00020; step();
    rd("R3", 4'h0, 8'h20);
    // R10 ack ignored while int_out is low
    glob_en = 1'b0; step();
    irq("R8", 8'h00);
    int_ack = 1'b1; step();
    rd("R10", 4'h8, 8'h0F);
    glob_en = 1'b1; step();
    irq("R10", 8'h90);
    // R1 reset mid-run
    rst = 1'b1; step(); rst = 1'b0;
    chk("R1", int'(int_out), 0);
    rd("R1", 4'h8, 8'h00);
    rd("R1", 4'h9, 8'h00);
    finish_run();
  end
endmodule